// File: doc/BRIEF.md
# Compact Immediate Constant Encoder and Expander

This block decides whether an arbitrary 32-bit constant can be carried as a 12-bit immediate field of a fixed-width instruction, and returns that 12-bit field when it can. Two encoding schemes are supported and picked per request by `in_mode`.

The rotate scheme accepts a byte rotated right by an even distance. The extended scheme accepts a plain byte, three byte-replication patterns, and a byte with its top bit set that is shifted left anywhere inside the word. The same block also holds the expander, which turns any 12-bit field back into its 32-bit value. A code generator or an assembler back end can use it to test candidate constants and to check that an encoding round-trips.

Each request is one cycle with `in_valid` high. The encoder result and the expander result for that request appear together on the next clock edge, marked by `out_valid`. The outputs hold their values until the next accepted request.

Top module: `imm_codec`

## Requirements
- R1: With `in_mode` = 0 (rotate scheme), a value is encodable exactly when it equals an 8-bit byte rotated right by 2*k for some k in 0..15. The code is {k[3:0], byte[7:0]}.
- R2: With `in_mode` = 1 (extended scheme), a value below 0x100 encodes as {4'b0000, XY}. A value 0x00XY00XY encodes as {4'b0001, XY}, 0xXY00XY00 as {4'b0010, XY}, and 0xXYXYXYXY as {4'b0011, XY}.
- R3: With `in_mode` = 1, a value equal to {1, b[6:0]} rotated right by s, for s in 8..31, encodes as {s[4:0], b[6:0]}. Examples: 0x0001B000 gives 0xBD8 and 0x00000100 gives 0xF80.
- R4: When several rotations fit in the rotate scheme, the smallest k is reported. Examples: 0x000003F0 gives 0xE3F and 0x00000100 gives 0xC01.
- R5: A value that does not fit the selected scheme gives `out_encodable` = 0 and `out_enc` = 0. Example: 0x0001B207 in both modes.
- R6: The value 0 encodes as 0x000 with `out_encodable` = 1 in both modes.
- R7: `out_expanded` is the value that `in_code` stands for under `in_mode`, following the layouts of R1, R2 and R3. In extended mode a code whose two top bits are not 00 follows R3.
- R8: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. While `in_valid` is low, `out_encodable`, `out_enc` and `out_expanded` keep their values.
- R9: While `rst_n` is low, `out_valid`, `out_encodable`, `out_enc` and `out_expanded` are all 0.
- R10: Every one of the 4096 codes in each mode expands to a value that is reported encodable in that mode, and the code reported for it expands back to the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| in_mode | input | 1 | 0 selects the rotate scheme, 1 selects the extended scheme |
| in_value | input | 32 | Constant to encode |
| in_code | input | 12 | Immediate field to expand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_encodable | output | 1 | The constant fits the selected scheme |
| out_enc | output | 12 | Encoded field, 0 when not encodable |
| out_expanded | output | 32 | Value of `in_code` under `in_mode` |

## Verification
The hardest cases are the boundary codes that real constants seldom reach. These are shifts that put the top byte bit at word bit 31, a 24-place shift, replicated patterns in every byte, and rotations that wrap across bit 0. A short vector list cannot cover all of them. The bench therefore walks all 4096 codes in each mode, expands each one with its own model, and feeds the result back as a constant. It then requires the constant to be reported encodable and the returned code to expand to the same value. A directed table covers the non-encodable values, the choice between several legal rotations, and the contrast between the two schemes.

// File: rtl/imm_pkg.sv
package imm_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned ROT_W   = 4;
  localparam int unsigned CODE_W  = ROT_W + IMM_W;
  localparam int unsigned SHAMT_W = $clog2(WORD_W);
  localparam int unsigned ROT_N   = 1 << ROT_W;
  localparam int unsigned SHIFT_LO = IMM_W;
  localparam int unsigned SHIFT_N  = WORD_W - SHIFT_LO;
  localparam int unsigned FORM_N   = 5;

  typedef enum logic {
    MODE_ROT = 1'b0,
    MODE_EXT = 1'b1
  } imm_mode_e;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v,
                                             input logic [SHAMT_W-1:0] n);
    return (v << n) | (v >> (7'd32 - 7'(n)));
  endfunction

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] v,
                                             input logic [SHAMT_W-1:0] n);
    return (v >> n) | (v << (7'd32 - 7'(n)));
  endfunction

endpackage

// File: rtl/imm_rot_search.sv
module imm_rot_search
  import imm_pkg::*;
(
  input  logic [WORD_W-1:0] value,
  output logic              hit,
  output logic [CODE_W-1:0] code
);

  logic [ROT_N-1:0]  fit;
  logic [WORD_W-1:0] rolled [ROT_N];

  // one rotator per even distance; undoing a right rotation by 2k
  // is a left rotation by 2k
  for (genvar g = 0; g < ROT_N; g++) begin : g_rot
    assign rolled[g] = rotl(value, SHAMT_W'(2 * g));
    assign fit[g]    = (rolled[g][WORD_W-1:IMM_W] == '0);
  end

  // smallest distance wins: scan downward so the lowest fit lands last
  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int r = ROT_N - 1; r >= 0; r--) begin
      if (fit[r]) begin
        hit  = 1'b1;
        code = {ROT_W'(r), rolled[r][IMM_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/imm_ext_search.sv
module imm_ext_search
  import imm_pkg::*;
(
  input  logic [WORD_W-1:0]  value,
  output logic               hit,
  output logic [CODE_W-1:0]  code,
  output logic [FORM_N-1:0]  form_hits,
  output logic [SHIFT_N-1:0] shift_map
);

  logic [IMM_W-1:0] lo_b;
  logic [IMM_W-1:0] mid_b;
  logic             plain_hit;
  logic             pair_lo_hit;
  logic             pair_hi_hit;
  logic             quad_hit;
  logic             shift_hit;
  logic [CODE_W-1:0] shift_code;

  logic [WORD_W-1:0]  srolled [SHIFT_N];

  assign lo_b  = value[IMM_W-1:0];
  assign mid_b = value[2*IMM_W-1:IMM_W];

  // replicated-byte detectors; a zero byte is left to the plain form
  assign plain_hit   = (value[WORD_W-1:IMM_W] == '0);
  assign pair_lo_hit = (value == {8'h00, lo_b, 8'h00, lo_b}) && (lo_b != '0);
  assign pair_hi_hit = (value == {mid_b, 8'h00, mid_b, 8'h00}) && (mid_b != '0);
  assign quad_hit    = (value == {4{lo_b}}) && (lo_b != '0);

  // shifted form: byte with msb set, rotated right by 8..31
  for (genvar g = 0; g < SHIFT_N; g++) begin : g_shift
    assign srolled[g]   = rotl(value, SHAMT_W'(g + SHIFT_LO));
    assign shift_map[g] = (srolled[g][WORD_W-1:IMM_W] == '0) &&
                          srolled[g][IMM_W-1];
  end

  always_comb begin
    shift_hit  = 1'b0;
    shift_code = '0;
    for (int i = SHIFT_N - 1; i >= 0; i--) begin
      if (shift_map[i]) begin
        shift_hit  = 1'b1;
        shift_code = {SHAMT_W'(i + SHIFT_LO), srolled[i][IMM_W-2:0]};
      end
    end
  end

  // plain and replicated forms ahead of the shifted form
  always_comb begin
    hit  = 1'b1;
    code = '0;
    if (plain_hit) begin
      code = {4'b0000, lo_b};
    end else if (pair_lo_hit) begin
      code = {4'b0001, lo_b};
    end else if (pair_hi_hit) begin
      code = {4'b0010, mid_b};
    end else if (quad_hit) begin
      code = {4'b0011, lo_b};
    end else if (shift_hit) begin
      code = shift_code;
    end else begin
      hit  = 1'b0;
    end
  end

  assign form_hits = {shift_hit, quad_hit, pair_hi_hit, pair_lo_hit, plain_hit};

endmodule

// File: rtl/imm_expand.sv
module imm_expand
  import imm_pkg::*;
(
  input  logic              mode,
  input  logic [CODE_W-1:0] code,
  output logic [WORD_W-1:0] value
);

  logic [IMM_W-1:0]  xy;
  logic [WORD_W-1:0] rot_val;
  logic [WORD_W-1:0] shift_val;
  logic [WORD_W-1:0] ext_val;

  assign xy        = code[IMM_W-1:0];
  assign rot_val   = rotr({{(WORD_W-IMM_W){1'b0}}, xy},
                          {code[CODE_W-1:IMM_W], 1'b0});
  assign shift_val = rotr({{(WORD_W-IMM_W){1'b0}}, 1'b1, code[IMM_W-2:0]},
                          code[CODE_W-1:IMM_W-1]);

  always_comb begin
    if (code[CODE_W-1:CODE_W-2] != 2'b00) begin
      ext_val = shift_val;
    end else begin
      unique case (code[IMM_W+1:IMM_W])
        2'b00:   ext_val = {24'h0, xy};
        2'b01:   ext_val = {8'h00, xy, 8'h00, xy};
        2'b10:   ext_val = {xy, 8'h00, xy, 8'h00};
        default: ext_val = {4{xy}};
      endcase
    end
  end

  assign value = (mode == MODE_EXT) ? ext_val : rot_val;

endmodule

// File: rtl/imm_codec.sv
module imm_codec
  import imm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic [WORD_W-1:0] in_value,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic              out_encodable,
  output logic [CODE_W-1:0] out_enc,
  output logic [WORD_W-1:0] out_expanded
);

  logic               rot_hit;
  logic [CODE_W-1:0]  rot_code;
  logic               ext_hit;
  logic [CODE_W-1:0]  ext_code;
  logic [FORM_N-1:0]  ext_forms;
  logic [SHIFT_N-1:0] ext_shift_map;
  logic [WORD_W-1:0]  exp_val;

  logic               sel_hit;
  logic [CODE_W-1:0]  sel_code;

  logic               valid_d, valid_q;
  logic               hit_d, hit_q;
  logic [CODE_W-1:0]  enc_d, enc_q;
  logic [WORD_W-1:0]  expd_d, expd_q;
  logic [WORD_W-1:0]  value_d, value_q;
  logic               mode_d, mode_q;
  logic [WORD_W-1:0]  chk_value;

  imm_rot_search u_rot (
    .value (in_value),
    .hit   (rot_hit),
    .code  (rot_code)
  );

  imm_ext_search u_ext (
    .value     (in_value),
    .hit       (ext_hit),
    .code      (ext_code),
    .form_hits (ext_forms),
    .shift_map (ext_shift_map)
  );

  imm_expand u_expand (
    .mode  (in_mode),
    .code  (in_code),
    .value (exp_val)
  );

  // expander on the registered result, used for the round-trip property
  imm_expand u_check (
    .mode  (mode_q),
    .code  (enc_q),
    .value (chk_value)
  );

  assign sel_hit  = (in_mode == MODE_EXT) ? ext_hit  : rot_hit;
  assign sel_code = (in_mode == MODE_EXT) ? ext_code : rot_code;

  // next state with explicit capture enable
  always_comb begin
    valid_d = in_valid;
    hit_d   = hit_q;
    enc_d   = enc_q;
    expd_d  = expd_q;
    value_d = value_q;
    mode_d  = mode_q;
    if (in_valid) begin
      hit_d   = sel_hit;
      enc_d   = sel_hit ? sel_code : '0;
      expd_d  = exp_val;
      value_d = in_value;
      mode_d  = in_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      enc_q   <= '0;
      expd_q  <= '0;
      value_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      hit_q   <= hit_d;
      enc_q   <= enc_d;
      expd_q  <= expd_d;
      value_q <= value_d;
      mode_q  <= mode_d;
    end
  end

  assign out_valid     = valid_q;
  assign out_encodable = hit_q;
  assign out_enc       = enc_q;
  assign out_expanded  = expd_q;

  // R8: result strobe tracks the request strobe one cycle later
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_enc) && $stable(out_encodable) &&
                   $stable(out_expanded)));

  // R5: a miss carries an all-zero field
  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_encodable |-> (out_enc == '0));

  // R10: the search result expands back to the constant it came from
  p_roundtrip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_encodable) |-> (chk_value == value_q));

  // R6: zero always encodes as the all-zero field
  p_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (value_q == '0)) |-> (out_encodable && (out_enc == '0)));

  // R3: extended forms never overlap, and one shift at most fits
  p_forms_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_forms));
  p_shift_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ext_shift_map));

endmodule

// File: tb/tb_imm_codec.sv
module tb_imm_codec;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_mode;
  logic [31:0] in_value;
  logic [11:0] in_code;
  logic        out_valid;
  logic        out_encodable;
  logic [11:0] out_enc;
  logic [31:0] out_expanded;

  int checks;
  int errors;
  bit done;

  imm_codec dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_mode       (in_mode),
    .in_value      (in_value),
    .in_code       (in_code),
    .out_valid     (out_valid),
    .out_encodable (out_encodable),
    .out_enc       (out_enc),
    .out_expanded  (out_expanded)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mode, value, encodable, code}, with the tag of the requirement
  localparam int NV = 26;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 32'h00000000, 1'b1, 12'h000},  // R6
    {1'b1, 32'h00000000, 1'b1, 12'h000},  // R6
    {1'b0, 32'h0001B000, 1'b1, 12'hA1B},  // R1
    {1'b1, 32'h0001B000, 1'b1, 12'hBD8},  // R3
    {1'b0, 32'h0001B207, 1'b0, 12'h000},  // R5
    {1'b1, 32'h0001B207, 1'b0, 12'h000},  // R5
    {1'b0, 32'hFF000000, 1'b1, 12'h4FF},  // R1
    {1'b1, 32'hFF000000, 1'b1, 12'h47F},  // R3
    {1'b0, 32'hF000000F, 1'b1, 12'h2FF},  // R1 wrap
    {1'b1, 32'hF000000F, 1'b0, 12'h000},  // R5
    {1'b1, 32'h00AB00AB, 1'b1, 12'h1AB},  // R2
    {1'b0, 32'h00AB00AB, 1'b0, 12'h000},  // R5
    {1'b1, 32'hAB00AB00, 1'b1, 12'h2AB},  // R2
    {1'b1, 32'h5A5A5A5A, 1'b1, 12'h35A},  // R2
    {1'b0, 32'h5A5A5A5A, 1'b0, 12'h000},  // R5
    {1'b1, 32'h000000FF, 1'b1, 12'h0FF},  // R2
    {1'b0, 32'h000000FF, 1'b1, 12'h0FF},  // R1
    {1'b1, 32'h00000100, 1'b1, 12'hF80},  // R3
    {1'b0, 32'h00000100, 1'b1, 12'hC01},  // R4
    {1'b0, 32'h000003FC, 1'b1, 12'hFFF},  // R1
    {1'b1, 32'h000003FC, 1'b1, 12'hF7F},  // R3
    {1'b0, 32'h000001FE, 1'b0, 12'h000},  // R5 odd shift
    {1'b1, 32'h000001FE, 1'b1, 12'hFFF},  // R3
    {1'b0, 32'h000003F0, 1'b1, 12'hE3F},  // R4
    {1'b0, 32'h80000001, 1'b1, 12'h106},  // R1
    {1'b1, 32'h80000001, 1'b0, 12'h000}   // R5
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model of the field layouts, rotating one bit per step
  function automatic logic [31:0] ref_expand(input logic m, input logic [11:0] c);
    logic [31:0] w;
    int amt;
    amt = 0;
    if (!m) begin
      w   = {24'h0, c[7:0]};
      amt = 2 * int'(c[11:8]);
    end else if (c[11:10] != 2'b00) begin
      w   = {24'h0, 1'b1, c[6:0]};
      amt = int'(c[11:7]);
    end else begin
      case (c[9:8])
        2'b00:   w = {24'h0, c[7:0]};
        2'b01:   w = {8'h0, c[7:0], 8'h0, c[7:0]};
        2'b10:   w = {c[7:0], 8'h0, c[7:0], 8'h0};
        default: w = {c[7:0], c[7:0], c[7:0], c[7:0]};
      endcase
    end
    for (int k = 0; k < amt; k++) w = {w[0], w[31:1]};
    return w;
  endfunction

  // one request cycle; returns at the falling edge after the capture edge
  task automatic send(input logic m, input logic [31:0] v, input logic [11:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_mode  = m;
    in_value = v;
    in_code  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_mode  = 1'b0;
    in_value = '0;
    in_code  = '0;
    repeat (3) @(negedge clk);

    // R9: state during reset
    check(out_valid == 1'b0, "R9 valid", 32'(out_valid), 32'd0);
    check(out_encodable == 1'b0, "R9 encodable", 32'(out_encodable), 32'd0);
    check(out_enc == '0, "R9 enc", 32'(out_enc), 32'd0);
    check(out_expanded == '0, "R9 expanded", out_expanded, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: encoder result and expansion of the expected code
    for (int i = 0; i < NV; i++) begin
      logic        m;
      logic [31:0] v;
      logic        h;
      logic [11:0] c;
      {m, v, h, c} = VEC[i];
      send(m, v, c);
      check(out_valid == 1'b1, "R8 valid pulse", 32'(out_valid), 32'd1);
      check(out_encodable == h, "R1-table encodable", 32'(out_encodable), 32'(h));
      check(out_enc == c, "R1-table code", 32'(out_enc), 32'(c));
      if (h) check(out_expanded == v, "R7 expand", out_expanded, v);
    end

    // R8: outputs hold while no request is given
    send(1'b0, 32'h0001B000, 12'hA1B);
    in_value = 32'h0001B207;
    in_mode  = 1'b1;
    in_code  = 12'h355;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle valid", 32'(out_valid), 32'd0);
    @(negedge clk);
    check(out_encodable == 1'b1, "R8 hold encodable", 32'(out_encodable), 32'd1);
    check(out_enc == 12'hA1B, "R8 hold code", 32'(out_enc), 32'hA1B);
    check(out_expanded == 32'h0001B000, "R8 hold expanded", out_expanded, 32'h0001B000);

    // R7 and R10: every code of both modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4096; c++) begin
        logic [31:0] v;
        v = ref_expand(m[0], 12'(c));
        send(m[0], v, 12'(c));
        check(out_expanded == v, "R7 expand all", out_expanded, v);
        check(out_encodable == 1'b1, "R10 encodable", 32'(out_encodable), 32'd1);
        check(ref_expand(m[0], out_enc) == v, "R10 round trip",
              ref_expand(m[0], out_enc), v);
      end
    end

    // R9: reset in the middle of a run clears a nonzero result
    send(1'b1, 32'h5A5A5A5A, 12'h35A);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9 mid valid", 32'(out_valid), 32'd0);
    check(out_enc == '0, "R9 mid enc", 32'(out_enc), 32'd0);
    check(out_expanded == '0, "R9 mid expanded", out_expanded, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule